// File: doc/BRIEF.md
# Windowed Atomic Word Memory

This block is a word-wide memory that several masters share. One physical array is seen through four equal-sized address windows. The window that a request's address falls in decides what happens to the addressed word:

- the plain window reads, writes or swaps;
- the set window ORs a mask into the word;
- the clear window removes the mask bits from the word;
- the add window adds an operand to the word.

Increment and decrement are adds of +1 and of all ones. Every access is one read-modify-write that no other request can split. Back-to-back requests to the same word are forwarded through the pipeline, so each one sees the result of the request before it.

A master sends a request with an address, write data, a two-bit command and a tag. It receives exactly one response, in request order, carrying the read data, an error flag and the same tag. An aligned address that lies inside the implemented depth and inside the four windows is served. Any other address is refused with an error and leaves the memory as it was.

Top module: `aliased_atomic_mem`

## Requirements
- R1: While reset is asserted and right after it is released, `rsp_valid` is 0 and every word of the memory reads as 0.
- R2: Window 0 (address bits [27:26] = 0): command 0 returns the word, command 1 stores `req_wdata`, and command 2 stores `req_wdata` and returns the prior word.
- R3: Window 1 (bits [27:26] = 1): commands 1 and 2 replace the word with word OR `req_wdata`, and command 2 also returns the prior word.
- R4: Window 2 (bits [27:26] = 2): commands 1 and 2 replace the word with word AND NOT `req_wdata`, and command 2 also returns the prior word.
- R5: Window 3 (bits [27:26] = 3): commands 1 and 2 replace the word with word + `req_wdata` modulo 2^32, so +1 increments and 0xFFFF_FFFF decrements. Command 2 also returns the prior word.
- R6: All four windows reach the same storage. Address bits [25:2] give the word index, and command 0 reads the word in any window.
- R7: A request is refused when bits [1:0] are not zero, when the word index is not below DEPTH, when bits [31:28] are not zero, or when the command is 3. A refused request gets `rsp_err`=1 and `rsp_data`=0, and the memory is not changed.
- R8: One request may be accepted on each clock edge. Its response is valid in the cycle after the second rising edge that follows acceptance. Responses come in request order, and `rsp_tag` equals `req_tag`.
- R9: Requests on consecutive cycles to the same word each see the result of the one before, with no stall.
- R10: Command 1 in any window, and every refused request, return `rsp_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Byte address; bits [27:26] select the window |
| req_cmd | input | 2 | 0 read, 1 modify, 2 modify and return prior, 3 illegal |
| req_wdata | input | 32 | Write data, mask or addend |
| req_tag | input | TAG_W | Request tag |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_data | output | 32 | Returned word or 0 |
| rsp_err | output | 1 | Request was refused |
| rsp_tag | output | TAG_W | Tag of the answered request |

## Verification
The latency and tag assertions assume that `req_valid` is low while reset is held. Without that, a request seen during reset would be matched two cycles later against a response the reset had removed. They also assume that `req_tag` is stable in the cycle `req_valid` is high. The stimulus drives inputs only on falling edges, keeps `req_valid` low through every reset, and holds each request for exactly one edge. The check that a write has landed assumes no reset between the write and the next edge. The bench never asserts reset in the cycle that follows a write.

// File: rtl/aam_pkg.sv
// Shared types for the windowed atomic memory.
// Assumes window spacing of 1 << WIN_LSB bytes from address zero.
package aam_pkg;
    localparam int WIN_LSB = 26;

    typedef enum logic [1:0] {
        WIN_PLAIN = 2'd0,
        WIN_SET   = 2'd1,
        WIN_CLR   = 2'd2,
        WIN_ADD   = 2'd3
    } win_e;

    typedef enum logic [1:0] {
        CMD_READ    = 2'd0,
        CMD_MOD     = 2'd1,
        CMD_MOD_RET = 2'd2,
        CMD_BAD     = 2'd3
    } cmd_e;
endpackage

// File: rtl/aam_decode.sv
// Splits a byte address into window and word index and flags refused requests.
// Assumes: ADDR_W > WIN_LSB + 2; the four windows are the only mapped space.
module aam_decode
    import aam_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 64,
    parameter int IDX_W  = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  cmd_e              cmd,
    output win_e              win,
    output logic [IDX_W-1:0]  idx,
    output logic              err
);
    localparam int OFF_W = WIN_LSB - 2;

    logic [OFF_W-1:0] word_off;
    logic             misaligned, too_deep, outside, bad_cmd;

    // Decode the address fields and the refusal causes.
    always_comb begin
        word_off   = addr[WIN_LSB-1:2];
        misaligned = addr[1:0] != 2'b00;
        too_deep   = word_off >= OFF_W'(DEPTH);
        outside    = addr[ADDR_W-1:WIN_LSB+2] != '0;
        bad_cmd    = cmd == CMD_BAD;
        win        = win_e'(addr[WIN_LSB+1:WIN_LSB]);
        idx        = word_off[IDX_W-1:0];
        err        = misaligned | too_deep | outside | bad_cmd;
    end
endmodule

// File: rtl/aam_alu.sv
// Computes the new word for one read-modify-write and whether to store it.
// Assumes old_val is the current (forwarded) value of the addressed word.
module aam_alu
    import aam_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              valid,
    input  logic              err,
    input  win_e              win,
    input  cmd_e              cmd,
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] new_val,
    output logic              store,
    output logic [DATA_W-1:0] ret_val
);
    // Select the window's operation and the value handed back.
    always_comb begin
        unique case (win)
            WIN_PLAIN: new_val = operand;
            WIN_SET:   new_val = old_val | operand;
            WIN_CLR:   new_val = old_val & ~operand;
            default:   new_val = old_val + operand;
        endcase
        store   = valid && !err && (cmd == CMD_MOD || cmd == CMD_MOD_RET);
        ret_val = (!err && (cmd == CMD_READ || cmd == CMD_MOD_RET)) ? old_val : '0;
    end
endmodule

// File: rtl/aam_store.sv
// Word array with one asynchronous read port and one synchronous write port.
// Cleared by reset. Assumes waddr < DEPTH whenever we is high.
module aam_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] words [DEPTH];

    // Clear on reset, otherwise commit the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) words[i] <= '0;
        end else if (we) begin
            words[waddr] <= wdata;
        end
    end

    // Present the addressed word.
    always_comb rdata = words[raddr];

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> words[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/aliased_atomic_mem.sv
// Windowed atomic memory. Stage A registers the decoded request.
// Stage A then reads the word, forwarding the value stage B is about to
// write. Stage B applies the operation, writes the array and drives the
// response. Assumes one request per cycle at most and no backpressure.
module aliased_atomic_mem
    import aam_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_cmd,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_err,
    output logic [TAG_W-1:0]  rsp_tag
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    win_e              dec_win;
    logic [IDX_W-1:0]  dec_idx;
    logic              dec_err;

    logic              a_valid, a_err;
    win_e              a_win;
    cmd_e              a_cmd;
    logic [IDX_W-1:0]  a_idx;
    logic [DATA_W-1:0] a_wdata, a_mem, a_old;
    logic [TAG_W-1:0]  a_tag;

    logic              b_valid, b_err;
    win_e              b_win;
    cmd_e              b_cmd;
    logic [IDX_W-1:0]  b_idx;
    logic [DATA_W-1:0] b_wdata, b_old, b_new, b_ret;
    logic [TAG_W-1:0]  b_tag;
    logic              b_store;

    aam_decode #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) dec_i (
        .addr(req_addr), .cmd(cmd_e'(req_cmd)),
        .win(dec_win), .idx(dec_idx), .err(dec_err)
    );

    aam_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) store_i (
        .clk(clk), .rst_n(rst_n),
        .we(b_store), .waddr(b_idx), .wdata(b_new),
        .raddr(a_idx), .rdata(a_mem)
    );

    aam_alu #(.DATA_W(DATA_W)) alu_i (
        .valid(b_valid), .err(b_err), .win(b_win), .cmd(b_cmd),
        .old_val(b_old), .operand(b_wdata),
        .new_val(b_new), .store(b_store), .ret_val(b_ret)
    );

    // Stage A: capture the decoded request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_valid <= 1'b0;
            a_err   <= 1'b0;
            a_win   <= WIN_PLAIN;
            a_cmd   <= CMD_READ;
            a_idx   <= '0;
            a_wdata <= '0;
            a_tag   <= '0;
        end else begin
            a_valid <= req_valid;
            a_err   <= dec_err;
            a_win   <= dec_win;
            a_cmd   <= cmd_e'(req_cmd);
            a_idx   <= dec_idx;
            a_wdata <= req_wdata;
            a_tag   <= req_tag;
        end
    end

    // Forward stage B's pending write when it targets the word stage A reads.
    always_comb a_old = (b_store && b_idx == a_idx) ? b_new : a_mem;

    // Stage B: hold the request and its prior word for the modify and reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_valid <= 1'b0;
            b_err   <= 1'b0;
            b_win   <= WIN_PLAIN;
            b_cmd   <= CMD_READ;
            b_idx   <= '0;
            b_wdata <= '0;
            b_tag   <= '0;
            b_old   <= '0;
        end else begin
            b_valid <= a_valid;
            b_err   <= a_err;
            b_win   <= a_win;
            b_cmd   <= a_cmd;
            b_idx   <= a_idx;
            b_wdata <= a_wdata;
            b_tag   <= a_tag;
            b_old   <= a_old;
        end
    end

    // Drive the response channel from stage B.
    always_comb begin
        rsp_valid = b_valid;
        rsp_err   = b_valid && b_err;
        rsp_data  = b_valid ? b_ret : '0;
        rsp_tag   = b_tag;
    end

    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid, 2));
    a_r8_tag_echo: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_tag == $past(req_tag, 2));
    a_r7_refused_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (!b_store && rsp_data == '0));
    a_r10_quiet_modify: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_cmd, 2) == 2'd1) |-> rsp_data == '0);
endmodule

// File: tb/aliased_atomic_mem_tb_top.sv
// Bench: a vector table walked once, then reset, streaming and reset-clear tests.
module aliased_atomic_mem_tb_top;
    localparam int CLK_P = 10;
    localparam int NV    = 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_cmd = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_tag = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_data;
    logic [3:0]  rsp_tag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    aliased_atomic_mem dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_cmd(req_cmd), .req_wdata(req_wdata), .req_tag(req_tag),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
        .rsp_tag(rsp_tag)
    );

    // Stimulus table: address, command, operand, expected data, expected error, requirement.
    localparam logic [31:0] V_ADDR [NV] = '{
        32'h0000_000C, 32'h0000_000C, 32'h0400_000C, 32'h0400_000C,
        32'h0800_000C, 32'h0800_000C, 32'h0C00_000C, 32'h0C00_000C,
        32'h0000_000C, 32'h0C00_000C, 32'h0400_000C, 32'h0000_000E,
        32'h0000_0100, 32'h1000_000C, 32'h0000_000C, 32'h0000_000C,
        32'h0000_00FC, 32'h0C00_00FC};
    localparam logic [1:0] V_CMD [NV] = '{
        2'd1, 2'd0, 2'd1, 2'd2, 2'd1, 2'd2, 2'd1, 2'd2,
        2'd2, 2'd2, 2'd0, 2'd1, 2'd1, 2'd1, 2'd3, 2'd0, 2'd1, 2'd0};
    localparam logic [31:0] V_OP [NV] = '{
        32'h1234_5678, 32'h0, 32'h0000_00F0, 32'h8000_0000,
        32'h0000_00FF, 32'h9000_0000, 32'h1, 32'hFFFF_FFFF,
        32'hFFFF_FFFF, 32'h1, 32'h0, 32'h0000_AAAA,
        32'h5, 32'h5, 32'h5, 32'h0, 32'hCAFE_F00D, 32'h0};
    localparam logic [31:0] V_EXP [NV] = '{
        32'h0, 32'h1234_5678, 32'h0, 32'h1234_56F8,
        32'h0, 32'h9234_5600, 32'h0, 32'h0234_5601,
        32'h0234_5600, 32'hFFFF_FFFF, 32'h0, 32'h0,
        32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'hCAFE_F00D};
    localparam logic V_ERR [NV] = '{
        1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
        1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
    // Requirement per row: R2 write, R2 read, R3 set, R3 test-set, R4 clear,
    // R4 test-clear, R5 increment, R5 decrement, R2 swap, R5 wrap, R6 alias read,
    // R7 misaligned, R7 too deep, R7 outside, R7 bad command, R7 unchanged,
    // R10 quiet write, R6 last word through add window.
    localparam int V_REQ [NV] = '{2, 2, 3, 3, 4, 4, 5, 5, 2, 5, 6, 7, 7, 7, 7, 7, 10, 6};

    task automatic check(input bit ok, input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Send one request and check its response two edges later.
    task automatic one_req(input logic [31:0] a, input logic [1:0] c,
                           input logic [31:0] d, input logic [3:0] t,
                           input logic [31:0] exp, input logic exp_err, input int req);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_cmd = c; req_wdata = d; req_tag = t;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check(rsp_valid === 1'b1, 8, "rsp_valid", {31'b0, rsp_valid}, 32'h1);
        check(rsp_data === exp && rsp_err === exp_err, req, "data/err",
              {rsp_err, rsp_data[30:0]}, {exp_err, exp[30:0]});
        check(rsp_tag === t, 8, "tag", {28'b0, rsp_tag}, {28'b0, t});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(rsp_valid === 1'b0, 1, "rsp_valid in reset", {31'b0, rsp_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid === 1'b0, 1, "rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
    endtask

    initial begin
        do_reset();
        // R1: memory reads zero after reset.
        one_req(32'h0000_000C, 2'd0, 32'h0, 4'hA, 32'h0, 1'b0, 1);

        for (int i = 0; i < NV; i++)
            one_req(V_ADDR[i], V_CMD[i], V_OP[i], 4'(i), V_EXP[i], V_ERR[i], V_REQ[i]);

        // R9: four back-to-back requests to word 5, checked as they stream out.
        begin
            logic [31:0] exp_s [4] = '{32'h0, 32'h5, 32'hA, 32'hF};
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (k >= 2) begin
                    check(rsp_valid === 1'b1, 8, "stream valid", {31'b0, rsp_valid}, 32'h1);
                    check(rsp_data === exp_s[k-2] && rsp_tag === 4'(k-2), 9,
                          "stream data", rsp_data, exp_s[k-2]);
                end
                if (k < 4) begin
                    req_valid = 1'b1;
                    req_addr  = (k < 3) ? 32'h0C00_0014 : 32'h0000_0014;
                    req_cmd   = (k < 3) ? 2'd2 : 2'd0;
                    req_wdata = 32'h5;
                    req_tag   = 4'(k);
                end else begin
                    req_valid = 1'b0;
                end
            end
        end

        // R1: a second reset clears stored words.
        do_reset();
        one_req(32'h0000_00FC, 2'd0, 32'h0, 4'h3, 32'h0, 1'b0, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule